// File: doc/BRIEF.md
# Receive Cell Interrupt Status Register

This block is the receive-side interrupt status byte of a cell-based physical-layer device. Seven status and event lines come in from the receive cell path: loss of cell delineation, header error detected, header error corrected, cell received, idle cell received, non-matching cell received and non-zero flow-control field received. Each line has its own interrupt enable. When an enabled line makes a qualifying transition, the block sets a sticky flag. The flag stays set until software reads the byte. Any set flag raises an active-high interrupt output.

Loss of delineation is a persistent condition, so its flag is set when the condition starts and again when it ends. The other six causes are momentary events and set their flag only on a rising edge. A read strobe returns the byte as it stands and clears every flag at the next clock edge. An edge that arrives in the same cycle as the read is kept for the next read.

The status lines are registered once, and edges are found by comparing each line with its value from the previous cycle. The previous-value registers update every cycle whatever the enables are. The design is built from an edge detector, a bank of sticky flags and a byte packer. It has no state machine: the only state is the previous-value register and the flag register.

Top module: `rx_cell_irq_reg`

## Requirements
- R1: After reset, rd_data is 0x00 and irq is 0. All stored previous-status values are 0.
- R2: Cause 0 (loss of delineation) is dual-edge. When its enable is 1, a 0-to-1 or a 1-to-0 change of status_in[0] sets rd_data bit 0 one clock later.
- R3: Causes 1 to 6 are single-edge. A 0-to-1 change of their status_in bit sets their flag. A 1-to-0 change leaves the flag unchanged.
- R4: A transition while the cause's enable bit is 0 never sets the flag. Setting the enable to 1 while the input is steady does not set it either.
- R5: A cycle with rd_stb=1 shows the flags as they were before the clear on rd_data. After the following clock edge, every flag is cleared unless R6 applies.
- R6: A qualifying enabled edge in the same cycle as rd_stb leaves that flag set after the clear.
- R7: Bit 2 of rd_data is reserved and always reads 0.
- R8: Bit map of rd_data, by cause index:
  - status_in[0] maps to bit 0.
  - status_in[1] maps to bit 1.
  - status_in[2] maps to bit 3.
  - status_in[3] maps to bit 4.
  - status_in[4] maps to bit 5.
  - status_in[5] maps to bit 6.
  - status_in[6] maps to bit 7.
- R9: irq is 1 exactly when some flag is set. It falls in the cycle after a clearing read that leaves no flag set.
- R10: Without a read, a set flag stays set whatever its input and enable do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_in | input | 7 | Status/event lines, indexed by cause (0 = loss of delineation, 1 = header error detected, 2 = cell received, 3 = idle cell, 4 = non-matching cell, 5 = non-zero flow-control field, 6 = header error corrected) |
| enable | input | 7 | Per-cause interrupt enable, same indexing as status_in |
| rd_stb | input | 1 | Register read strobe; clears the flags at the next edge |
| rd_data | output | 8 | Interrupt status byte (map in R8) |
| irq | output | 1 | Active-high interrupt, OR of all flags |

## Verification
The checker watches several rules on every cycle:
- the reserved bit stays 0;
- irq always agrees with the byte;
- no flag rises without its enable in the previous cycle;
- a single-edge flag only rises after its input was high;
- flags stay set while no read occurs;
- a read with all enables off empties the byte.

Some behaviours need the bench's scenarios, which compare against a reference model:
- the set-on-fall behaviour of the delineation bit;
- the lack of a false edge when an enable is turned on;
- keeping an edge that collides with a read;
- the exact bit position of each cause.

// File: rtl/rx_cell_irq_pkg.sv
package rx_cell_irq_pkg;
    localparam int NUM_CAUSES = 7;
    localparam int REG_W      = 8;
    localparam int RSVD_POS   = 2;
    // register bit position for each cause index
    localparam int unsigned BIT_POS [NUM_CAUSES] = '{0, 1, 3, 4, 5, 6, 7};
    // causes captured on both edges (persistent conditions)
    localparam logic [NUM_CAUSES-1:0] DUAL_MASK = 7'b000_0001;
endpackage

// File: rtl/rx_cell_irq_edge.sv
module rx_cell_irq_edge #(
    parameter int W = 7,
    parameter logic [W-1:0] DUAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] ev
);
    logic [W-1:0] prev_q;

    // previous value always tracks, independent of enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (DUAL[i]) begin : g_dual
            assign ev[i] = sig[i] ^ prev_q[i];
        end else begin : g_rise
            assign ev[i] = sig[i] & ~prev_q[i];
        end
    end
endmodule

// File: rtl/rx_cell_irq_flags.sv
module rx_cell_irq_flags #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic [W-1:0] en,
    input  logic         clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] keep;
    logic [W-1:0] flags_d;

    always_comb begin
        keep    = clr ? '0 : flags;
        // new qualified edge wins over the clearing read
        flags_d = keep | (set_ev & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_d;
    end
endmodule

// File: rtl/rx_cell_irq_pack.sv
module rx_cell_irq_pack
    import rx_cell_irq_pkg::*;
(
    input  logic [NUM_CAUSES-1:0] flags,
    output logic [REG_W-1:0]      byte_out
);
    always_comb begin
        byte_out = '0;
        for (int i = 0; i < NUM_CAUSES; i++) begin
            byte_out[BIT_POS[i]] = flags[i];
        end
        byte_out[RSVD_POS] = 1'b0;
    end
endmodule

// File: rtl/rx_cell_irq_reg.sv
module rx_cell_irq_reg
    import rx_cell_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CAUSES-1:0] status_in,
    input  logic [NUM_CAUSES-1:0] enable,
    input  logic                  rd_stb,
    output logic [REG_W-1:0]      rd_data,
    output logic                  irq
);
    logic [NUM_CAUSES-1:0] edge_ev;
    logic [NUM_CAUSES-1:0] flags;

    rx_cell_irq_edge #(
        .W   (NUM_CAUSES),
        .DUAL(DUAL_MASK)
    ) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (status_in),
        .ev   (edge_ev)
    );

    rx_cell_irq_flags #(
        .W(NUM_CAUSES)
    ) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_ev(edge_ev),
        .en    (enable),
        .clr   (rd_stb),
        .flags (flags)
    );

    rx_cell_irq_pack pack_i (
        .flags   (flags),
        .byte_out(rd_data)
    );

    assign irq = |flags;
endmodule

// File: rtl/rx_cell_irq_chk.sv
module rx_cell_irq_chk
    import rx_cell_irq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_CAUSES-1:0] status_in,
    input logic [NUM_CAUSES-1:0] enable,
    input logic                  rd_stb,
    input logic [REG_W-1:0]      rd_data,
    input logic                  irq
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RSVD_POS] == 1'b0); // R7

    AST_IRQ_MATCHES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (rd_data != '0)); // R9

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((rd_data & $past(rd_data)) == $past(rd_data))); // R10

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && enable == '0) |=> (rd_data == '0)); // R5

    for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_cause
        AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(rd_data[BIT_POS[i]]) && rd_data[BIT_POS[i]]) |-> $past(enable[i])); // R4
        if (!DUAL_MASK[i]) begin : g_single
            AST_SINGLE_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(rd_data[BIT_POS[i]]) && rd_data[BIT_POS[i]]) |-> $past(status_in[i])); // R3
        end
    end
endmodule

bind rx_cell_irq_reg rx_cell_irq_chk chk_i (.*);

// File: tb/rx_cell_irq_reg_tb_top.sv
`timescale 1ns/1ps
module rx_cell_irq_reg_tb_top;
    localparam int NC = 7;
    localparam logic [6:0] EN = 7'h7F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] status_in = '0;
    logic [6:0] enable = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0] m_prev = '0;
    logic [6:0] m_flags = '0;

    always #2 clk = ~clk;

    rx_cell_irq_reg dut_i (
        .clk(clk), .rst_n(rst_n), .status_in(status_in), .enable(enable),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    // bit map from R8
    function automatic logic [7:0] pack_exp(input logic [6:0] f);
        int pos [7] = '{0, 1, 3, 4, 5, 6, 7};
        logic [7:0] b = '0;
        for (int i = 0; i < NC; i++) b[pos[i]] = f[i];
        return b;
    endfunction

    function automatic logic [6:0] next_flags(input logic [6:0] f, input logic [6:0] p,
                                              input logic [6:0] s, input logic [6:0] e,
                                              input logic r);
        logic [6:0] ev;
        ev = s & ~p;
        ev[0] = s[0] ^ p[0];          // R2 dual-edge cause
        return (r ? 7'h00 : f) | (ev & e);
    endfunction

    task automatic expect_state(input string tag, input logic [7:0] exp_b);
        checks++;
        if (rd_data !== exp_b || irq !== (exp_b != 0)) begin
            errors++;
            $display("FAIL %s: rd_data=%02h irq=%0b expected rd_data=%02h irq=%0b",
                     tag, rd_data, irq, exp_b, exp_b != 0);
        end
    endtask

    // called at a negedge; drives, checks, advances one cycle
    task automatic step(input string tag, input logic [6:0] s, input logic [6:0] e, input logic r);
        status_in = s; enable = e; rd_stb = r;
        #1;
        expect_state(tag, pack_exp(m_flags));
        m_flags = next_flags(m_flags, m_prev, s, e, r);
        m_prev  = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pos [7] = '{0, 1, 3, 4, 5, 6, 7};
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        expect_state("R1 reset", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R1 after release", 8'h00);

        // R2: dual edge on cause 0
        step("R2 idle", 7'h00, EN, 1'b0);
        step("R2 rise", 7'h01, EN, 1'b0);
        expect_state("R2 rise sets bit0", 8'h01);
        step("R5 pre-clear data", 7'h01, EN, 1'b1);
        expect_state("R5 cleared / R9 irq low", 8'h00);
        step("R2 fall", 7'h00, EN, 1'b0);
        expect_state("R2 fall sets bit0", 8'h01);
        step("R5 clear", 7'h00, EN, 1'b1);

        // R3 / R8: each single-edge cause on rise, not on fall
        for (int i = 1; i < NC; i++) begin
            step("R3 rise", 7'(1 << i), EN, 1'b0);
            expect_state("R8 bit position", 8'(1 << pos[i]));
            step("R3 fall with read", 7'h00, EN, 1'b1);
            expect_state("R3 fall does not set", 8'h00);
        end

        // R4: disabled edges and enabling a steady input
        step("R4 base", 7'h00, 7'h00, 1'b0);
        step("R4 rise disabled", 7'h7F, 7'h00, 1'b0);
        expect_state("R4 disabled rise", 8'h00);
        step("R4 enable steady", 7'h7F, EN, 1'b0);
        expect_state("R4 no false edge", 8'h00);
        step("R4 falls", 7'h00, EN, 1'b0);
        expect_state("R4 only dual bit on fall", 8'h01);
        step("R5 clear", 7'h00, EN, 1'b1);

        // R6: edge collides with read
        step("R6 set", 7'h01, EN, 1'b0);
        step("R6 read+fall", 7'h00, EN, 1'b1);
        expect_state("R6 edge kept", 8'h01);
        step("R6 read", 7'h00, EN, 1'b1);
        expect_state("R9 irq falls after read", 8'h00);

        // R10: sticky without read
        step("R10 rise", 7'h02, EN, 1'b0);
        step("R10 fall", 7'h00, 7'h00, 1'b0);
        step("R10 hold", 7'h00, 7'h00, 1'b0);
        expect_state("R10 still set", 8'h02);
        step("R5 clear", 7'h00, EN, 1'b1);

        // R7: all causes rise
        step("R7 all rise", 7'h7F, EN, 1'b0);
        expect_state("R7 reserved zero, R9 irq high", 8'hFB);
        step("R5 clear", 7'h7F, EN, 1'b1);

        // random stimulus against the model
        for (int n = 0; n < 400; n++) begin
            logic [6:0] s;
            logic [6:0] e;
            logic r;
            s = 7'($urandom);
            e = ($urandom_range(0, 3) == 0) ? 7'h00 : 7'($urandom);
            r = ($urandom_range(0, 3) == 0);
            step("R8 random", s, e, r);
        end
        step("R8 random final", 7'h00, 7'h00, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule